// File: doc/BRIEF.md
# Dual-Port Memory Collision Guard

This block is a 1K x 8 word store with two independent access ports, left and right, plus the logic that decides which port owns a word when both touch it at once. Each port has an enable, a write strobe, a 10-bit address and write data. A read on a port returns the stored word one clock after the address is presented.

In master operation the block compares the two ports every cycle. If both are enabled on the same address, the port that began its access in an earlier cycle wins. The other port sees its active-low busy output go low in that same cycle, and its write is dropped inside the block. A port begins an access when its enable rises or when its address changes while it stays enabled. If both ports begin in the same cycle, the left port wins. Ownership is held for as long as the collision lasts. When the collision ends, the next collision is decided afresh.

In slave operation the block generates no busy signals. Two active-low busy inputs, driven by an arbiter elsewhere, block writes on their own port. Busy is kept on separate input and output pins instead of one bidirectional pin. The data interface is a plain synchronous memory port with no back-pressure: an enabled access is always taken in its cycle, and a blocked write is dropped, not stalled. A read made while its port is blocked still returns the stored word, and a stale flag is raised beside it.

Top module: `dpram_guard`

## Requirements
- R1: In master mode, when either port is disabled or the two addresses differ, both busy outputs are high (1).
- R2: In master mode, if the left port began its access in an earlier cycle and the right port then enables on the same address, right busy goes low (0) in that same cycle and left busy stays high.
- R3: In master mode, if the right port began earlier and the left then collides with it, left busy goes low and right busy stays high.
- R4: When both ports begin an access to the same address in the same cycle, the left port wins: right busy is low and only the left write is stored.
- R5: The two busy outputs are never low in the same cycle.
- R6: Once a collision is decided, busy stays on the loser while the match persists. It is released in the cycle the winner disables or the addresses diverge. The next collision is then decided on arrival order again.
- R7: A write from a port whose busy output is low is dropped, and the word keeps its earlier value.
- R8: In slave mode (master_mode = 0) both busy outputs stay high, and a low busy input blocks writes on its own port. In master mode the busy inputs have no effect.
- R9: rd_stale rises one cycle after an enabled access made while that port was blocked, and is 0 after an access that was not blocked.
- R10: A write from a port that is not blocked is stored. rdata shows the word as it was before the edge, one cycle after the access (read before write).
- R11: After reset both busy outputs are high and both rdata and rd_stale are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = generate busy, 0 = take busy from the inputs |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | 10 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_busy_in_n | input | 1 | Left busy input in slave mode, active low |
| l_busy_out_n | output | 1 | Left busy output, active low |
| l_rdata | output | 8 | Left port read data, registered |
| l_rd_stale | output | 1 | Last left access was made while blocked |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | 10 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_busy_in_n | input | 1 | Right busy input in slave mode, active low |
| r_busy_out_n | output | 1 | Right busy output, active low |
| r_rdata | output | 8 | Right port read data, registered |
| r_rd_stale | output | 1 | Last right access was made while blocked |

## Verification
The assertions assume that in slave mode the external arbiter never drives both busy inputs low at once. They also assume that all port inputs settle between clock edges, because the busy outputs are combinational on the current enables and addresses. The stimulus changes every input only on the falling edge. It keeps at least one busy input high whenever slave mode is selected. It samples busy half a cycle before the edge that would commit a write.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NPORT = 2;
  localparam int unsigned P_L   = 0;
  localparam int unsigned P_R   = 1;
endpackage

// File: rtl/dpg_track.sv
// Flags the cycle in which a port begins a new access: enable rising,
// or the address moving while the port stays enabled.
module dpg_track #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          fresh
);
  logic          en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  assign fresh = en && (!en_q || (addr != addr_q));
endmodule

// File: rtl/dpg_arbiter.sv
// Decides the owner of a colliding word by arrival order and holds it
// while the collision lasts.
module dpg_arbiter
  import dpg_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          en,
  input  logic [NPORT-1:0][AW-1:0]  addr,
  input  logic [NPORT-1:0]          fresh,
  output logic [NPORT-1:0]          lose
);
  owner_e owner_q, owner_d, winner;
  logic   match;

  assign match = en[P_L] && en[P_R] && (addr[P_L] == addr[P_R]);

  always_comb begin
    if (owner_q != OWN_NONE)                winner = owner_q;
    else if (fresh[P_L] && !fresh[P_R])     winner = OWN_RIGHT;
    else if (fresh[P_R] && !fresh[P_L])     winner = OWN_LEFT;
    else                                    winner = OWN_LEFT;
    owner_d = match ? winner : OWN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  assign lose[P_L] = match && (winner == OWN_RIGHT);
  assign lose[P_R] = match && (winner == OWN_LEFT);
endmodule

// File: rtl/dpg_mem.sv
// Word store with two ports: registered read-before-write, gated writes.
module dpg_mem
  import dpg_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          en,
  input  logic [NPORT-1:0]          we,
  input  logic [NPORT-1:0]          blk,
  input  logic [NPORT-1:0][AW-1:0]  addr,
  input  logic [NPORT-1:0][DW-1:0]  wdata,
  output logic [NPORT-1:0][DW-1:0]  rdata,
  output logic [NPORT-1:0]          stale
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [NPORT-1:0] wr_ok;

  assign wr_ok = en & we & ~blk;

  // Right port is applied last; only one of them can pass a colliding write.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (wr_ok[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[gp] <= '0;
        stale[gp] <= 1'b0;
      end else if (en[gp]) begin
        rdata[gp] <= mem[addr[gp]];
        stale[gp] <= blk[gp];
      end
    end
  end
endmodule

// File: rtl/dpram_guard.sv
module dpram_guard
  import dpg_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_busy_in_n,
  output logic          l_busy_out_n,
  output logic [DW-1:0] l_rdata,
  output logic          l_rd_stale,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  input  logic          r_busy_in_n,
  output logic          r_busy_out_n,
  output logic [DW-1:0] r_rdata,
  output logic          r_rd_stale
);
  logic [NPORT-1:0]          en, we, fresh, lose, blk, busy_in_n, stale;
  logic [NPORT-1:0][AW-1:0]  addr;
  logic [NPORT-1:0][DW-1:0]  wdata, rdata;

  assign en        = {r_en, l_en};
  assign we        = {r_we, l_we};
  assign addr      = {r_addr, l_addr};
  assign wdata     = {r_wdata, l_wdata};
  assign busy_in_n = {r_busy_in_n, l_busy_in_n};

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
    dpg_track #(.AW(AW)) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en[gp]),
      .addr  (addr[gp]),
      .fresh (fresh[gp])
    );
    assign blk[gp] = master_mode ? lose[gp] : !busy_in_n[gp];
  end

  dpg_arbiter #(.AW(AW)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .addr  (addr),
    .fresh (fresh),
    .lose  (lose)
  );

  dpg_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .we    (we),
    .blk   (blk),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .stale (stale)
  );

  assign l_busy_out_n = !(master_mode && lose[P_L]);
  assign r_busy_out_n = !(master_mode && lose[P_R]);
  assign l_rdata      = rdata[P_L];
  assign r_rdata      = rdata[P_R];
  assign l_rd_stale   = stale[P_L];
  assign r_rd_stale   = stale[P_R];
endmodule

// File: rtl/dpram_guard_chk.sv
module dpram_guard_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_mode,
  input logic          l_en,
  input logic          r_en,
  input logic [AW-1:0] l_addr,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_in_n,
  input logic          r_busy_in_n,
  input logic          l_busy_out_n,
  input logic          r_busy_out_n,
  input logic          l_rd_stale,
  input logic          r_rd_stale
);
  logic past_ok, match, l_blk, r_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign match = l_en && r_en && (l_addr == r_addr);
  assign l_blk = master_mode ? !l_busy_out_n : !l_busy_in_n;
  assign r_blk = master_mode ? !r_busy_out_n : !r_busy_in_n;

  a_r5_never_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_out_n && !r_busy_out_n));

  a_r1_quiet_without_match: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> (l_busy_out_n && r_busy_out_n));

  a_r8_slave_outputs_high: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_out_n && r_busy_out_n));

  a_r6_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && master_mode && $past(master_mode) && $past(match) && match
     && !$past(r_busy_out_n)) |-> !r_busy_out_n);

  a_r6_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && master_mode && $past(master_mode) && $past(match) && match
     && !$past(l_busy_out_n)) |-> !l_busy_out_n);

  a_r9_left_stale: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_blk) |=> l_rd_stale);

  a_r9_right_stale: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_blk) |=> r_rd_stale);
endmodule

bind dpram_guard dpram_guard_chk #(.AW(AW)) u_chk (.*);

// File: tb/dpram_guard_tb.sv
module dpram_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_en = 0, l_we = 0, l_busy_in_n = 1;
  logic r_en = 0, r_we = 0, r_busy_in_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic l_busy_out_n, r_busy_out_n, l_rd_stale, r_rd_stale;
  logic [DW-1:0] l_rdata, r_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_guard #(.AW(AW), .DW(DW)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_en = 0; l_we = 0; r_en = 0; r_we = 0;
  endtask

  // single write on one side (0 = left, 1 = right), others idle
  task automatic wr(bit side, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    idle();
    if (!side) begin l_en = 1; l_we = 1; l_addr = a; l_wdata = d; end
    else       begin r_en = 1; r_we = 1; r_addr = a; r_wdata = d; end
    @(negedge clk);
    idle();
  endtask

  task automatic rd(bit side, logic [AW-1:0] a, output logic [DW-1:0] d, output logic st);
    @(negedge clk);
    idle();
    if (!side) begin l_en = 1; l_addr = a; end
    else       begin r_en = 1; r_addr = a; end
    @(negedge clk);
    d  = side ? r_rdata : l_rdata;
    st = side ? r_rd_stale : l_rd_stale;
    idle();
  endtask

  task automatic t_reset();
    check("R11 l_busy", l_busy_out_n, 1);
    check("R11 r_busy", r_busy_out_n, 1);
    check("R11 l_rdata", l_rdata, 0);
    check("R11 r_rdata", r_rdata, 0);
    check("R11 stale", {l_rd_stale, r_rd_stale}, 0);
  endtask

  task automatic t_write_read();
    logic [DW-1:0] d; logic st;
    wr(0, 10'h055, 8'h5A);
    rd(1, 10'h055, d, st);
    check("R10 right reads left write", d, 8'h5A);
    check("R9 stale clear", st, 0);
    wr(1, 10'h3FF, 8'h3C);
    rd(0, 10'h3FF, d, st);
    check("R10 left reads right write", d, 8'h3C);
    // read-before-write on the same port
    @(negedge clk);
    l_en = 1; l_we = 1; l_addr = 10'h055; l_wdata = 8'h66;
    @(negedge clk);
    idle();
    check("R10 read before write", l_rdata, 8'h5A);
    rd(0, 10'h055, d, st);
    check("R10 new value stored", d, 8'h66);
  endtask

  task automatic t_nomatch();
    @(negedge clk);
    l_en = 1; l_addr = 10'h001; r_en = 1; r_addr = 10'h002;
    #1;
    check("R1 diff addr", {l_busy_out_n, r_busy_out_n}, 2'b11);
    @(negedge clk);
    l_en = 0; r_en = 1; l_addr = 10'h002;
    #1;
    check("R1 one disabled", {l_busy_out_n, r_busy_out_n}, 2'b11);
    idle();
  endtask

  task automatic t_left_first();
    logic [DW-1:0] d; logic st;
    wr(0, 10'h100, 8'h11);
    @(negedge clk);
    l_en = 1; l_addr = 10'h100;
    @(negedge clk);
    r_en = 1; r_we = 1; r_addr = 10'h100; r_wdata = 8'h77;
    #1;
    check("R2 right busy", r_busy_out_n, 0);
    check("R2 left free", l_busy_out_n, 1);
    @(negedge clk);
    r_we = 0;
    #1;
    check("R9 right stale", r_rd_stale, 1);
    check("R6 busy held", r_busy_out_n, 0);
    @(negedge clk);
    l_en = 0;
    #1;
    check("R6 released", r_busy_out_n, 1);
    @(negedge clk);
    l_en = 1;
    #1;
    check("R6 re-decided left busy", l_busy_out_n, 0);
    check("R6 re-decided right free", r_busy_out_n, 1);
    idle();
    rd(0, 10'h100, d, st);
    check("R7 right write dropped", d, 8'h11);
  endtask

  task automatic t_right_first();
    logic [DW-1:0] d; logic st;
    wr(1, 10'h200, 8'h33);
    @(negedge clk);
    r_en = 1; r_addr = 10'h200;
    @(negedge clk);
    l_en = 1; l_we = 1; l_addr = 10'h200; l_wdata = 8'h22;
    #1;
    check("R3 left busy", l_busy_out_n, 0);
    check("R3 right free", r_busy_out_n, 1);
    @(negedge clk);
    idle();
    check("R9 left stale", l_rd_stale, 1);
    rd(1, 10'h200, d, st);
    check("R7 left write dropped", d, 8'h33);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] d; logic st;
    @(negedge clk);
    l_en = 1; l_we = 1; l_addr = 10'h300; l_wdata = 8'h44;
    r_en = 1; r_we = 1; r_addr = 10'h300; r_wdata = 8'h55;
    #1;
    check("R4 tie right busy", {l_busy_out_n, r_busy_out_n}, 2'b10);
    @(negedge clk);
    idle();
    rd(1, 10'h300, d, st);
    check("R4 left write kept", d, 8'h44);
  endtask

  task automatic t_slave();
    logic [DW-1:0] d; logic st;
    wr(0, 10'h010, 8'h01);
    @(negedge clk);
    master_mode = 0; l_busy_in_n = 0;
    l_en = 1; l_we = 1; l_addr = 10'h010; l_wdata = 8'hAA;
    r_en = 1; r_we = 1; r_addr = 10'h010; r_wdata = 8'hBB;
    #1;
    check("R8 slave busy out high", {l_busy_out_n, r_busy_out_n}, 2'b11);
    @(negedge clk);
    idle();
    check("R9 slave left stale", l_rd_stale, 1);
    l_busy_in_n = 1;
    rd(0, 10'h010, d, st);
    check("R8 blocked left, right stored", d, 8'hBB);
    @(negedge clk);
    master_mode = 1; l_busy_in_n = 0;
    wr(0, 10'h010, 8'hCC);
    rd(1, 10'h010, d, st);
    check("R8 busy input ignored in master", d, 8'hCC);
    l_busy_in_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_nomatch();
    t_left_first();
    t_right_first();
    t_same_cycle();
    t_slave();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule